// File: doc/BRIEF.md
# Byte-Loadable 16-bit Up/Down Address Register

This block is a 16-bit address register for a CPU whose data path is one byte wide. It can serve as a program counter, a stack pointer or an index register. The value is kept in four 4-bit counter slices. Each slice tells the slice above it, in the same cycle, whether it will carry or borrow. It does this by looking at its current value and the count request, and does not wait for its own sum.

Either byte of the register can be loaded from the shared 8-bit data bus on a rising clock edge. The register also increments, decrements and holds on that edge. An asynchronous clear forces the value to zero. Three output paths are enabled independently and stay high impedance when disabled:
- the full 16-bit value onto the address bus;
- the upper byte onto the data bus;
- the lower byte onto the data bus.

All controls are active low. Because the data bus is shared, a byte can be copied inside the register in one edge: enable one byte's output and load the other byte.

Top module: `addr_reg16`

## Requirements
- R1: While `clr_n` is low the value is 0x0000, taking effect at once without a clock edge, and overriding every other control.
- R2: With `ld_hi_n` low at a rising edge, bits 15:8 take `data_bus[7:0]`; bits 7:0 keep their value unless `ld_lo_n` is also low.
- R3: With `ld_lo_n` low at a rising edge, bits 7:0 take `data_bus[7:0]`; bits 15:8 keep their value unless `ld_hi_n` is also low.
- R4: With only `inc_n` low, the value becomes value+1 modulo 2^16, so 0xFFFF becomes 0x0000.
- R5: With only `dec_n` low, the value becomes value-1 modulo 2^16, so 0x0000 becomes 0xFFFF.
- R6: A carry or borrow crosses every 4-bit slice boundary in the same edge. For example, 0x0FFF+1 gives 0x1000, 0x1000-1 gives 0x0FFF, and 0x00FF+1 gives 0x0100.
- R7: With `inc_n` and `dec_n` both low and no load, the value holds.
- R8: When a load and a count are requested at the same edge, only the load acts and the count is dropped.
- R9: `addr_bus` carries the full value while `oe_addr_n` is low, and is high impedance otherwise.
- R10: `data_bus` carries bits 15:8 while `oe_hi_n` is low, and bits 7:0 while only `oe_lo_n` is low. The upper byte wins when both are low. The register leaves `data_bus` high impedance when both are high.
- R11: With no control asserted, the value holds across edges.
- R12: With a byte output enabled and the other byte's load asserted, that edge copies one byte into the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every synchronous action uses its rising edge |
| clr_n | input | 1 | Asynchronous clear to zero, active low |
| ld_hi_n | input | 1 | Load upper byte from the data bus, active low |
| ld_lo_n | input | 1 | Load lower byte from the data bus, active low |
| inc_n | input | 1 | Increment request, active low |
| dec_n | input | 1 | Decrement request, active low |
| oe_addr_n | input | 1 | Drive the value onto the address bus, active low |
| oe_hi_n | input | 1 | Drive the upper byte onto the data bus, active low |
| oe_lo_n | input | 1 | Drive the lower byte onto the data bus, active low |
| addr_bus | output | 16 | Tri-state address bus output |
| data_bus | inout | 8 | Shared data bus: load source and tri-state byte output |

## Verification
The assertions take two things for granted:
- The data bus has exactly one driver whenever a load samples it, so the sampled byte is defined.
- Controls and clear change only away from the rising edge.

The bench drives every control on the falling edge and turns its own data-bus driver off before enabling a byte output. Its address-bus driver is used only while `oe_addr_n` is high. In that window the driver also proves that the register has let go of the bus. Clear is dropped between edges, so the zero value is seen with no clock edge in between.

// File: rtl/addr_reg16.sv
`timescale 1ns/1ps
module addr_reg16 #(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 4
) (
  input  logic                         clk,
  input  logic                         clr_n,
  input  logic                         ld_hi_n,
  input  logic                         ld_lo_n,
  input  logic                         inc_n,
  input  logic                         dec_n,
  input  logic                         oe_addr_n,
  input  logic                         oe_hi_n,
  input  logic                         oe_lo_n,
  output logic [SLICE_W*SLICES-1:0]    addr_bus,
  inout  wire  [SLICE_W*SLICES/2-1:0]  data_bus
);
  localparam int W    = SLICE_W * SLICES;
  localparam int BW   = W / 2;
  localparam int HALF = SLICES / 2;

  logic [W-1:0]      val;
  logic [SLICES-1:0] up_go, dn_go;
  logic              load_any;

  assign load_any = !ld_hi_n || !ld_lo_n;
  assign up_go[0] = !inc_n && dec_n && !load_any;
  assign dn_go[0] = !dec_n && inc_n && !load_any;

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    logic [SLICE_W-1:0] q;
    logic               ld_me;
    logic [SLICE_W-1:0] din;

    if (g >= HALF) begin : g_hi
      assign ld_me = !ld_hi_n;
    end else begin : g_lo
      assign ld_me = !ld_lo_n;
    end
    assign din = data_bus[(g % HALF)*SLICE_W +: SLICE_W];

    if (g < SLICES-1) begin : g_chain
      assign up_go[g+1] = up_go[g] && (&q);
      assign dn_go[g+1] = dn_go[g] && !(|q);
    end

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)        q <= '0;
      else if (ld_me)    q <= din;
      else if (up_go[g]) q <= q + 1'b1;
      else if (dn_go[g]) q <= q - 1'b1;
    end

    assign val[g*SLICE_W +: SLICE_W] = q;
  end

  assign addr_bus = oe_addr_n ? {W{1'bz}} : val;
  assign data_bus = !oe_hi_n ? val[W-1:BW] :
                    (!oe_lo_n ? val[BW-1:0] : {BW{1'bz}});
endmodule

// File: rtl/addr_reg16_chk.sv
`timescale 1ns/1ps
module addr_reg16_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           clr_n,
  input logic           ld_hi_n,
  input logic           ld_lo_n,
  input logic           inc_n,
  input logic           dec_n,
  input logic           oe_addr_n,
  input logic           oe_hi_n,
  input logic           oe_lo_n,
  input logic [W-1:0]   addr_bus,
  input logic [W/2-1:0] data_bus,
  input logic [W-1:0]   val
);
  localparam int BW = W / 2;

  assert_clear_zero_R1: assert property (@(posedge clk)
    !clr_n |-> val == '0);

  assert_load_hi_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_hi_n |=> val[W-1:BW] == $past(data_bus));

  assert_load_lo_R3: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_lo_n |=> val[BW-1:0] == $past(data_bus));

  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (!inc_n && dec_n && ld_hi_n && ld_lo_n) |=> val == W'($past(val) + 1));

  assert_dec_wrap_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (!dec_n && inc_n && ld_hi_n && ld_lo_n) |=> val == W'($past(val) - 1));

  assert_both_hold_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (!inc_n && !dec_n && ld_hi_n && ld_lo_n) |=> $stable(val));

  assert_load_beats_count_R8: assert property (@(posedge clk) disable iff (!clr_n)
    (!ld_hi_n && ld_lo_n && (!inc_n || !dec_n)) |=> $stable(val[BW-1:0]));

  assert_addr_drive_R9: assert property (@(posedge clk) disable iff (!clr_n)
    !oe_addr_n |-> addr_bus == val);

  assert_byte_drive_R10: assert property (@(posedge clk) disable iff (!clr_n)
    !oe_hi_n |-> data_bus == val[W-1:BW]);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!clr_n)
    (inc_n && dec_n && ld_hi_n && ld_lo_n) |=> $stable(val));
endmodule

bind addr_reg16 addr_reg16_chk #(.W(SLICE_W*SLICES)) chk_i (
  .clk(clk), .clr_n(clr_n), .ld_hi_n(ld_hi_n), .ld_lo_n(ld_lo_n),
  .inc_n(inc_n), .dec_n(dec_n), .oe_addr_n(oe_addr_n), .oe_hi_n(oe_hi_n),
  .oe_lo_n(oe_lo_n), .addr_bus(addr_bus), .data_bus(data_bus), .val(val)
);

// File: tb/addr_reg16_tb_top.sv
`timescale 1ns/1ps
module addr_reg16_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic clr_n = 1'b1;
  logic ld_hi_n = 1'b1, ld_lo_n = 1'b1, inc_n = 1'b1, dec_n = 1'b1;
  logic oe_addr_n = 1'b1, oe_hi_n = 1'b1, oe_lo_n = 1'b1;
  logic        tb_ddrv = 1'b0, tb_adrv = 1'b0;
  logic [7:0]  tb_data = 8'h00;
  logic [15:0] tb_addr = 16'h0000;
  wire  [15:0] addr_bus;
  wire  [7:0]  data_bus;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  assign data_bus = tb_ddrv ? tb_data : 8'bz;
  assign addr_bus = tb_adrv ? tb_addr : 16'bz;

  always #(CLK_P/2) clk = ~clk;

  addr_reg16 dut_i (
    .clk(clk), .clr_n(clr_n), .ld_hi_n(ld_hi_n), .ld_lo_n(ld_lo_n),
    .inc_n(inc_n), .dec_n(dec_n), .oe_addr_n(oe_addr_n), .oe_hi_n(oe_hi_n),
    .oe_lo_n(oe_lo_n), .addr_bus(addr_bus), .data_bus(data_bus)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(output logic [15:0] v);
    oe_addr_n = 1'b0;
    #1;
    v = addr_bus;
    oe_addr_n = 1'b1;
    #1;
  endtask

  task automatic load_hi(input logic [7:0] b);
    tb_data = b; tb_ddrv = 1'b1; ld_hi_n = 1'b0;
    tick();
    ld_hi_n = 1'b1; tb_ddrv = 1'b0;
  endtask

  task automatic load_lo(input logic [7:0] b);
    tb_data = b; tb_ddrv = 1'b1; ld_lo_n = 1'b0;
    tick();
    ld_lo_n = 1'b1; tb_ddrv = 1'b0;
  endtask

  task automatic set16(input logic [15:0] v);
    load_hi(v[15:8]);
    load_lo(v[7:0]);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(v); chk("R1 reset value", v, 16'h0000);
  endtask

  task automatic t_loads();
    logic [15:0] v;
    load_lo(8'h34); rd(v); chk("R3 low load only", v, 16'h0034);
    load_hi(8'h12); rd(v); chk("R2 high load keeps low", v, 16'h1234);
    tb_data = 8'hAB; tb_ddrv = 1'b1; ld_hi_n = 1'b0; ld_lo_n = 1'b0;
    tick();
    ld_hi_n = 1'b1; ld_lo_n = 1'b1; tb_ddrv = 1'b0;
    rd(v); chk("R2 R3 both loads", v, 16'hABAB);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    set16(16'hFFFF);
    inc_n = 1'b0; tick(); inc_n = 1'b1;
    rd(v); chk("R4 increment wraps", v, 16'h0000);
    dec_n = 1'b0; tick(); dec_n = 1'b1;
    rd(v); chk("R5 decrement wraps", v, 16'hFFFF);
    set16(16'h1234);
    inc_n = 1'b0; tick(); tick(); inc_n = 1'b1;
    rd(v); chk("R4 two increments", v, 16'h1236);
  endtask

  task automatic t_lookahead();
    logic [15:0] v;
    set16(16'h0FFF);
    inc_n = 1'b0; tick(); inc_n = 1'b1;
    rd(v); chk("R6 carry across three slices", v, 16'h1000);
    dec_n = 1'b0; tick(); dec_n = 1'b1;
    rd(v); chk("R6 borrow across three slices", v, 16'h0FFF);
    set16(16'h00FF);
    inc_n = 1'b0; tick(); inc_n = 1'b1;
    rd(v); chk("R6 carry into byte boundary", v, 16'h0100);
    set16(16'hF000);
    dec_n = 1'b0; tick(); dec_n = 1'b1;
    rd(v); chk("R6 borrow from top slice", v, 16'hEFFF);
  endtask

  task automatic t_conflict();
    logic [15:0] v;
    set16(16'h1234);
    inc_n = 1'b0; dec_n = 1'b0; tick(); inc_n = 1'b1; dec_n = 1'b1;
    rd(v); chk("R7 inc and dec together hold", v, 16'h1234);
    tick(); tick();
    rd(v); chk("R11 idle holds", v, 16'h1234);
    tb_data = 8'h55; tb_ddrv = 1'b1; ld_lo_n = 1'b0; inc_n = 1'b0;
    tick();
    ld_lo_n = 1'b1; inc_n = 1'b1; tb_ddrv = 1'b0;
    rd(v); chk("R8 low load beats increment", v, 16'h1255);
    tb_data = 8'h00; tb_ddrv = 1'b1; ld_hi_n = 1'b0; dec_n = 1'b0;
    tick();
    ld_hi_n = 1'b1; dec_n = 1'b1; tb_ddrv = 1'b0;
    rd(v); chk("R8 high load beats decrement", v, 16'h0055);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    set16(16'hBEEF);
    #2 clr_n = 1'b0;
    #1 rd(v); chk("R1 clear without clock edge", v, 16'h0000);
    @(negedge clk);
    inc_n = 1'b0; tb_data = 8'h77; tb_ddrv = 1'b1; ld_hi_n = 1'b0;
    tick();
    inc_n = 1'b1; ld_hi_n = 1'b1; tb_ddrv = 1'b0;
    rd(v); chk("R1 clear overrides load and count", v, 16'h0000);
    clr_n = 1'b1;
    tick();
  endtask

  task automatic t_outputs();
    logic [15:0] v;
    set16(16'h1234);
    tb_addr = 16'hA5A5; tb_adrv = 1'b1; #1;
    chk("R9 address bus released", addr_bus, 16'hA5A5);
    tb_adrv = 1'b0;
    oe_addr_n = 1'b0; #1;
    chk("R9 address bus driven", addr_bus, 16'h1234);
    oe_addr_n = 1'b1;
    oe_hi_n = 1'b0; #1;
    chk("R10 upper byte out", {8'h00, data_bus}, 16'h0012);
    oe_hi_n = 1'b1; oe_lo_n = 1'b0; #1;
    chk("R10 lower byte out", {8'h00, data_bus}, 16'h0034);
    oe_hi_n = 1'b0; #1;
    chk("R10 upper byte wins", {8'h00, data_bus}, 16'h0012);
    oe_hi_n = 1'b1; oe_lo_n = 1'b1;
    tb_data = 8'h3C; tb_ddrv = 1'b1; #1;
    chk("R10 data bus released", {8'h00, data_bus}, 16'h003C);
    tb_ddrv = 1'b0;
    rd(v); chk("R11 outputs leave value alone", v, 16'h1234);
  endtask

  task automatic t_self_copy();
    logic [15:0] v;
    set16(16'h1234);
    oe_lo_n = 1'b0; ld_hi_n = 1'b0;
    tick();
    oe_lo_n = 1'b1; ld_hi_n = 1'b1;
    rd(v); chk("R12 copy low into high", v, 16'h3434);
    set16(16'h9A01);
    oe_hi_n = 1'b0; ld_lo_n = 1'b0;
    tick();
    oe_hi_n = 1'b1; ld_lo_n = 1'b1;
    rd(v); chk("R12 copy high into low", v, 16'h9A9A);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2 clr_n = 1'b0;
    @(negedge clk); @(negedge clk);
    t_reset();
    clr_n = 1'b1;
    tick();
    t_reset();
    t_loads();
    t_wrap();
    t_lookahead();
    t_conflict();
    t_clear();
    t_outputs();
    t_self_copy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule